// File: doc/BRIEF.md
# Processor Power State Controller

This block decides which clock domains of a low-power processor core run at any moment. It has four resting states: full power, doze, nap and sleep. It also has one transient state, pending, which it holds while it waits for the system to quiesce. Software asks for a low-power state by writing a small control word that carries three one-hot mode bits and an enable for dynamic unit gating. The block drives clock enables for the core pipeline, for each execution unit, for snoop logic, for the data cache and for the decrementer.

Nap and sleep stop snooping, so the block must not enter either state until system logic has agreed. It raises a quiesce request and stays in pending until the acknowledge arrives. Every low-power state returns only to full power, and only on a wake event that the state accepts. The block reports which source woke it in a one-cycle pulse, resolving simultaneous events by a fixed priority.

States and transitions: FULL goes to DOZE on a valid doze write, and to PEND on a valid nap or sleep write. PEND goes to NAP or SLEEP when the acknowledge arrives, and back to FULL on a wake event that the target state accepts. DOZE, NAP and SLEEP each go to FULL on an accepted wake event.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset the block is in full power (`pm_state` = 0), all clock enables are high, dynamic gating is off, `quiesce_req` is low and `wake_valid` is low.
- R2: The control word has these bits: bit 0 requests doze, bit 1 requests nap, bit 2 requests sleep and bit 3 enables dynamic gating. `pm_state` is encoded as 0 full, 1 doze, 2 nap, 3 sleep and 4 pending. A valid doze write in full power gives `pm_state` = 1 after the next clock edge.
- R3: A write with more than one mode bit set is discarded as a whole, including its dynamic-gating bit. The block stays in full power.
- R4: A valid nap or sleep write moves the block to pending. In pending `quiesce_req` is high and all clocks run as in full power. The block enters the target state on the edge where `quiesce_ack` is sampled high. `quiesce_req` stays high through nap and sleep.
- R5: In doze, only snoop, the decrementer and the data cache run, and the data cache runs only in cycles where `dc_req` is high. In nap, only the decrementer runs. In sleep, every enable is low. In all three, the core and unit enables are low.
- R6: In full power or pending with dynamic gating on, each `unit_clk_en` bit equals the matching `unit_busy` bit in the same cycle. With dynamic gating off, all unit enables are high.
- R7: Doze and nap wake on `wake_rst`, `ext_irq` or `dec_irq`. Sleep wakes only on `wake_rst` or `ext_irq`, and a `dec_irq` in sleep leaves it asleep.
- R8: On a wake, `wake_valid` is high for exactly one cycle, the cycle in which `pm_state` is first back to 0. `wake_src` then carries 1 for reset, 2 for external interrupt or 3 for decrementer. Reset is chosen over an external interrupt, and an external interrupt over the decrementer.
- R9: Control writes made outside full power are discarded, so no low-power state moves directly to another.
- R10: In pending, a wake event that the target state accepts returns the block to full power and drops `quiesce_req`. Such a wake takes precedence over an acknowledge in the same cycle. A `dec_irq` does not abort a pending sleep.
- R11: `quiesce_ack` outside pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: mode bits [2:0], dynamic gating [3] |
| unit_busy | input | N_UNITS | Per-unit dispatched-work flags |
| dc_req | input | 1 | Data cache access demand while dozing |
| quiesce_ack | input | 1 | System logic agrees to snoop shutdown |
| ext_irq | input | 1 | External asynchronous interrupt, synchronised |
| dec_irq | input | 1 | Decrementer interrupt |
| wake_rst | input | 1 | Reset-class wake request |
| pm_state | output | 3 | Current state code |
| quiesce_req | output | 1 | Request for snoop quiesce |
| core_clk_en | output | 1 | Core pipeline clock enable |
| unit_clk_en | output | N_UNITS | Execution unit clock enables |
| snoop_clk_en | output | 1 | Snoop logic clock enable |
| dcache_clk_en | output | 1 | Data cache clock enable |
| dec_clk_en | output | 1 | Decrementer clock enable |
| wake_valid | output | 1 | One-cycle wake report strobe |
| wake_src | output | 2 | Wake source code |

## Verification
The assertions assume that the wake inputs and `quiesce_ack` are already synchronised to `clk` and stable around the edge. They also assume that system logic raises the acknowledge only in answer to a request. The stimulus changes every input at the falling edge and leaves it steady through the next rising edge. It drives the acknowledge and wake events in pending, nap and sleep, and also in full power to show that they are inert there. Rows that present several wake sources at once exercise the priority order against each target state.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int CFG_W   = 4;
    localparam int CB_DOZE = 0;
    localparam int CB_NAP  = 1;
    localparam int CB_SLP  = 2;
    localparam int CB_DYN  = 3;

    typedef enum logic [2:0] {
        PS_FULL  = 3'd0,
        PS_DOZE  = 3'd1,
        PS_NAP   = 3'd2,
        PS_SLEEP = 3'd3,
        PS_PEND  = 3'd4
    } pstate_e;

    localparam logic [1:0] WK_NONE = 2'd0;
    localparam logic [1:0] WK_RST  = 2'd1;
    localparam logic [1:0] WK_EXT  = 2'd2;
    localparam logic [1:0] WK_DEC  = 2'd3;
endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
    import pwr_pkg::*;
(
    input  logic [CFG_W-1:0] wdata,
    output logic             accept,
    output logic             go_doze,
    output logic             go_nap,
    output logic             go_sleep,
    output logic             dyn_bit
);
    logic [1:0] n_modes;

    always_comb begin
        n_modes  = 2'(wdata[CB_DOZE]) + 2'(wdata[CB_NAP]) + 2'(wdata[CB_SLP]);
        accept   = (n_modes <= 2'd1);
        go_doze  = wdata[CB_DOZE];
        go_nap   = wdata[CB_NAP];
        go_sleep = wdata[CB_SLP];
        dyn_bit  = wdata[CB_DYN];
    end
endmodule

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb
    import pwr_pkg::*;
(
    input  logic       rst_i,
    input  logic       ext_i,
    input  logic       dec_i,
    input  logic       dec_ok,
    output logic       hit,
    output logic [1:0] src
);
    always_comb begin
        hit = 1'b1;
        if (rst_i)                src = WK_RST;
        else if (ext_i)           src = WK_EXT;
        else if (dec_i && dec_ok) src = WK_DEC;
        else begin
            src = WK_NONE;
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/pwr_unit_gate.sv
module pwr_unit_gate #(
    parameter int N_UNITS = 5
) (
    input  logic               core_on,
    input  logic               dyn_en,
    input  logic [N_UNITS-1:0] busy,
    output logic [N_UNITS-1:0] en
);
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        always_comb begin
            if (!core_on)    en[u] = 1'b0;
            else if (dyn_en) en[u] = busy[u];
            else             en[u] = 1'b1;
        end
    end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
    import pwr_pkg::*;
#(
    parameter int N_UNITS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_wdata,
    input  logic [N_UNITS-1:0] unit_busy,
    input  logic               dc_req,
    input  logic               quiesce_ack,
    input  logic               ext_irq,
    input  logic               dec_irq,
    input  logic               wake_rst,
    output logic [2:0]         pm_state,
    output logic               quiesce_req,
    output logic               core_clk_en,
    output logic [N_UNITS-1:0] unit_clk_en,
    output logic               snoop_clk_en,
    output logic               dcache_clk_en,
    output logic               dec_clk_en,
    output logic               wake_valid,
    output logic [1:0]         wake_src
);
    pstate_e    st_q, st_d, tgt_q, tgt_d;
    logic       dyn_q, dyn_d;
    logic       wv_q, wv_d;
    logic [1:0] ws_q, ws_d;

    logic       acc, go_doze, go_nap, go_sleep, dyn_bit;
    logic       dec_ok, wk_hit;
    logic [1:0] wk_src;
    logic       core_on;

    pwr_mode_decode u_dec (
        .wdata    (cfg_wdata),
        .accept   (acc),
        .go_doze  (go_doze),
        .go_nap   (go_nap),
        .go_sleep (go_sleep),
        .dyn_bit  (dyn_bit)
    );

    always_comb begin
        dec_ok = (st_q == PS_DOZE) || (st_q == PS_NAP) ||
                 ((st_q == PS_PEND) && (tgt_q == PS_NAP));
    end

    pwr_wake_arb u_arb (
        .rst_i  (wake_rst),
        .ext_i  (ext_irq),
        .dec_i  (dec_irq),
        .dec_ok (dec_ok),
        .hit    (wk_hit),
        .src    (wk_src)
    );

    // next-state process
    always_comb begin
        st_d  = st_q;
        tgt_d = tgt_q;
        dyn_d = dyn_q;
        wv_d  = 1'b0;
        ws_d  = WK_NONE;
        unique case (st_q)
            PS_FULL: begin
                if (cfg_we && acc) begin
                    dyn_d = dyn_bit;
                    if (go_doze) begin
                        st_d = PS_DOZE;
                    end else if (go_nap) begin
                        st_d  = PS_PEND;
                        tgt_d = PS_NAP;
                    end else if (go_sleep) begin
                        st_d  = PS_PEND;
                        tgt_d = PS_SLEEP;
                    end
                end
            end
            PS_PEND: begin
                if (wk_hit) begin
                    st_d = PS_FULL;
                    wv_d = 1'b1;
                    ws_d = wk_src;
                end else if (quiesce_ack) begin
                    st_d = tgt_q;
                end
            end
            PS_DOZE, PS_NAP, PS_SLEEP: begin
                if (wk_hit) begin
                    st_d = PS_FULL;
                    wv_d = 1'b1;
                    ws_d = wk_src;
                end
            end
            default: st_d = PS_FULL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_FULL;
            tgt_q <= PS_NAP;
            dyn_q <= 1'b0;
            wv_q  <= 1'b0;
            ws_q  <= WK_NONE;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
            dyn_q <= dyn_d;
            wv_q  <= wv_d;
            ws_q  <= ws_d;
        end
    end

    // output process
    always_comb begin
        core_on       = 1'b0;
        snoop_clk_en  = 1'b0;
        dcache_clk_en = 1'b0;
        dec_clk_en    = 1'b0;
        quiesce_req   = 1'b0;
        unique case (st_q)
            PS_FULL: begin
                core_on       = 1'b1;
                snoop_clk_en  = 1'b1;
                dcache_clk_en = 1'b1;
                dec_clk_en    = 1'b1;
            end
            PS_PEND: begin
                core_on       = 1'b1;
                snoop_clk_en  = 1'b1;
                dcache_clk_en = 1'b1;
                dec_clk_en    = 1'b1;
                quiesce_req   = 1'b1;
            end
            PS_DOZE: begin
                snoop_clk_en  = 1'b1;
                dcache_clk_en = dc_req;
                dec_clk_en    = 1'b1;
            end
            PS_NAP: begin
                dec_clk_en    = 1'b1;
                quiesce_req   = 1'b1;
            end
            PS_SLEEP: begin
                quiesce_req   = 1'b1;
            end
            default: begin
                core_on = 1'b0;
            end
        endcase
    end

    pwr_unit_gate #(.N_UNITS(N_UNITS)) u_gate (
        .core_on (core_on),
        .dyn_en  (dyn_q),
        .busy    (unit_busy),
        .en      (unit_clk_en)
    );

    assign core_clk_en = core_on;
    assign pm_state    = st_q;
    assign wake_valid  = wv_q;
    assign wake_src    = ws_q;

    // R9
    no_lp_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {PS_DOZE, PS_NAP, PS_SLEEP}) |=>
        (st_q == $past(st_q) || st_q == PS_FULL));

    // R4
    hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q inside {PS_NAP, PS_SLEEP}) && st_q != $past(st_q)) |->
        ($past(st_q) == PS_PEND && $past(quiesce_ack)));

    // R7
    sleep_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SLEEP && !wake_rst && !ext_irq) |=> (st_q == PS_SLEEP));

    // R8
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (pm_state == 3'd0 && wake_src != WK_NONE) ##1 !wake_valid);

    // R8
    rst_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != PS_FULL && wake_rst) |=> (wake_valid && wake_src == WK_RST));

    // R5
    lp_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state inside {3'd1, 3'd2, 3'd3}) |-> (!core_clk_en && unit_clk_en == '0));
endmodule

// File: tb/sim_pwr_state_ctl.sv
module sim_pwr_state_ctl;
    localparam int CLK_P = 10;
    localparam int NU    = 5;

    typedef struct packed {
        logic          we;
        logic [3:0]    wd;
        logic [NU-1:0] busy;
        logic          dcr;
        logic          qa;
        logic          ex;
        logic          de;
        logic          rs;
        logic [2:0]    st;
        logic          q;
        logic [1:0]    src;
        logic [3:0]    ck;
        logic [NU-1:0] un;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 30;
    // fields: we wd busy dcr qa ex de rs | st q src {core,snoop,dc,dec} units req
    localparam vec_t VEC [NV] = '{
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,2'd0,4'b1111,5'b11111,4'd1},  // R1 idle
        '{1'b1,4'h3,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,2'd0,4'b1111,5'b11111,4'd3},  // R3 two modes
        '{1'b1,4'h8,5'b00101,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,2'd0,4'b1111,5'b00101,4'd6},  // R6 dyn on
        '{1'b0,4'h0,5'b10010,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,2'd0,4'b1111,5'b10010,4'd6},  // R6 follow busy
        '{1'b1,4'hB,5'b10010,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,2'd0,4'b1111,5'b10010,4'd3},  // R3 dyn kept
        '{1'b1,4'h9,5'b10010,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,2'd0,4'b0101,5'b00000,4'd2},  // R2 doze
        '{1'b1,4'h2,5'b00000,1'b1,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,2'd0,4'b0111,5'b00000,4'd9},  // R9 R5 dc demand
        '{1'b0,4'h0,5'b00001,1'b0,1'b0,1'b0,1'b1,1'b0, 3'd0,1'b0,2'd3,4'b1111,5'b00001,4'd7},  // R7 dec wake
        '{1'b0,4'h0,5'b00001,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,2'd0,4'b1111,5'b00001,4'd8},  // R8 pulse ends
        '{1'b1,4'hA,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b1,2'd0,4'b1111,5'b00000,4'd4},  // R4 nap req
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b1,2'd0,4'b1111,5'b00000,4'd4},  // R4 wait ack
        '{1'b0,4'h0,5'b00000,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b1,2'd0,4'b0001,5'b00000,4'd4},  // R4 nap
        '{1'b1,4'h9,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,2'd0,4'b0001,5'b00000,4'd9},  // R9 write in nap
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b1,1'b1,1'b0, 3'd0,1'b0,2'd2,4'b1111,5'b00000,4'd8},  // R8 ext over dec
        '{1'b1,4'hC,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b1,2'd0,4'b1111,5'b00000,4'd4},  // R4 sleep req
        '{1'b0,4'h0,5'b00000,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd3,1'b1,2'd0,4'b0000,5'b00000,4'd5},  // R5 sleep
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b0,1'b1,1'b0, 3'd3,1'b1,2'd0,4'b0000,5'b00000,4'd7},  // R7 dec ignored
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b1,1'b1,1'b1, 3'd0,1'b0,2'd1,4'b1111,5'b00000,4'd8},  // R8 rst first
        '{1'b1,4'hC,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b1,2'd0,4'b1111,5'b00000,4'd4},  // R4
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0,1'b0,2'd2,4'b1111,5'b00000,4'd10}, // R10 abort
        '{1'b0,4'h0,5'b00000,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd0,1'b0,2'd0,4'b1111,5'b00000,4'd11}, // R11 stray ack
        '{1'b1,4'hA,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b1,2'd0,4'b1111,5'b00000,4'd4},  // R4
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b0,1'b1,1'b0, 3'd0,1'b0,2'd3,4'b1111,5'b00000,4'd10}, // R10 dec nap
        '{1'b1,4'hC,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b1,2'd0,4'b1111,5'b00000,4'd4},  // R4
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b0,1'b1,1'b0, 3'd4,1'b1,2'd0,4'b1111,5'b00000,4'd10}, // R10 dec no abort
        '{1'b0,4'h0,5'b00000,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd3,1'b1,2'd0,4'b0000,5'b00000,4'd4},  // R4 sleep
        '{1'b0,4'h0,5'b00000,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0,1'b0,2'd2,4'b1111,5'b00000,4'd7},  // R7 ext wake
        '{1'b0,4'h0,5'b00011,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd0,1'b0,2'd0,4'b1111,5'b00011,4'd11}, // R11
        '{1'b1,4'hA,5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b1,2'd0,4'b1111,5'b00000,4'd4},  // R4
        '{1'b0,4'h0,5'b00000,1'b0,1'b1,1'b1,1'b0,1'b0, 3'd0,1'b0,2'd2,4'b1111,5'b00000,4'd10}  // R10 wake beats ack
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [3:0]    cfg_wdata;
    logic [NU-1:0] unit_busy;
    logic          dc_req, quiesce_ack, ext_irq, dec_irq, wake_rst;
    logic [2:0]    pm_state;
    logic          quiesce_req, core_clk_en, snoop_clk_en, dcache_clk_en, dec_clk_en;
    logic [NU-1:0] unit_clk_en;
    logic          wake_valid;
    logic [1:0]    wake_src;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    pwr_state_ctl #(.N_UNITS(NU)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .unit_busy(unit_busy), .dc_req(dc_req), .quiesce_ack(quiesce_ack),
        .ext_irq(ext_irq), .dec_irq(dec_irq), .wake_rst(wake_rst),
        .pm_state(pm_state), .quiesce_req(quiesce_req), .core_clk_en(core_clk_en),
        .unit_clk_en(unit_clk_en), .snoop_clk_en(snoop_clk_en),
        .dcache_clk_en(dcache_clk_en), .dec_clk_en(dec_clk_en),
        .wake_valid(wake_valid), .wake_src(wake_src)
    );

    function automatic logic [15:0] observed();
        return {pm_state, quiesce_req, wake_valid, wake_src, core_clk_en,
                snoop_clk_en, dcache_clk_en, dec_clk_en, unit_clk_en};
    endfunction

    task automatic check(input logic [15:0] exp, input int rq);
        logic [15:0] act;
        act = observed();
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cfg_we = v.we; cfg_wdata = v.wd; unit_busy = v.busy; dc_req = v.dcr;
        quiesce_ack = v.qa; ext_irq = v.ex; dec_irq = v.de; wake_rst = v.rs;
    endtask

    task automatic idle();
        cfg_we = 0; cfg_wdata = 0; unit_busy = 0; dc_req = 0;
        quiesce_ack = 0; ext_irq = 0; dec_irq = 0; wake_rst = 0;
    endtask

    initial begin
        #(CLK_P*200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (2) @(negedge clk);
        // R1 reset state
        check({3'd0, 1'b0, 1'b0, 2'd0, 4'b1111, 5'b11111}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(posedge clk);
            #(CLK_P/4);
            check({VEC[i].st, VEC[i].q, (VEC[i].src != 2'd0), VEC[i].src,
                   VEC[i].ck, VEC[i].un}, int'(VEC[i].rq));
            @(negedge clk);
        end
        // R1 directed: reset from doze with dynamic gating on clears everything
        idle();
        cfg_we = 1'b1; cfg_wdata = 4'h9;
        @(negedge clk);
        idle();
        // R2 doze reached
        check({3'd1, 1'b0, 1'b0, 2'd0, 4'b0101, 5'b00000}, 2);
        rst_n = 1'b0;
        #(CLK_P/4);
        // R1 asynchronous return to full power, dynamic gating off
        check({3'd0, 1'b0, 1'b0, 2'd0, 4'b1111, 5'b11111}, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 ack while idle in full power after reset
        quiesce_ack = 1'b1;
        @(negedge clk);
        check({3'd0, 1'b0, 1'b0, 2'd0, 4'b1111, 5'b11111}, 11);
        idle();
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule